// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a CPU register port and the serial shift engine of an SPI controller. It keeps two byte-wide queues of 32 entries each. Software loads the outgoing queue one 32-bit word at a time. The shift engine takes bytes from that queue one at a time. In the other direction, the engine drops each received byte into the incoming queue, and software pulls the bytes back out either four at a time or one at a time.

A status word holds both live byte counts next to seven flags:
- Three flags are plain level indicators of queue state.
- Four flags are sticky and stay set until software writes a one to their position.

An enable word chooses which flags may raise the single interrupt line. A mode word holds the two fill-level thresholds that the threshold flags compare against.

The register port is a single-cycle strobe interface. Writes take effect at the clock edge. Read data is combinational from the address, so it is valid in the same cycle as the read strobe. A read of the receive queue removes its bytes at the edge that ends that cycle.

Register offsets:

| Offset | Register |
|--------|----------|
| 0x00 | Mode |
| 0x04 | Status / clear |
| 0x08 | Interrupt enable |
| 0x10 | Transmit push |
| 0x14 | Receive pop |

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset the mode word (offset 0x00) reads 0x0000_0403 (transmit threshold 4 in [13:8], receive threshold 3 in [5:0]), the enable word (0x08) reads 0, the status word (0x04) reads 0x0000_8900, and `irq` is low.
- R2: A write to offset 0x10 queues the four data bytes with [31:24] first, keeping only as many as there are free entries in the 32-entry queue. `tx_valid` is high exactly while bytes are queued, `tx_byte` shows the oldest byte, and `tx_take` with `tx_valid` removes it.
- R3: A 32-bit read of offset 0x14 (`reg_byte`=0) removes up to four bytes and returns them with the oldest in [31:24]. Byte lanes with no stored byte read as zero.
- R4: An 8-bit read of offset 0x14 (`reg_byte`=1) removes one byte and returns it in [7:0]. A read of either size from an empty receive queue returns 0 and leaves the count at 0.
- R5: The status flags bit 15 (transmit queue empty), bit 9 (receive queue not empty) and bit 8 (transmit queue not full) follow the queue state and are unaffected by clear writes.
- R6: Bit 14 (transfer done) is set by a `xfer_done` pulse and stays set until it is cleared.
- R7: Bit 11 is set when the transmit count is at or below mode[13:8]. Bit 13 is set when the receive count is greater than mode[5:0]. Both are sticky.
- R8: Bit 12 is set when the receive count reaches 32 and is sticky. A received byte that arrives while the queue is full is dropped, and the count stays at 32.
- R9: Writing offset 0x04 clears each sticky flag whose bit is one in the write data and keeps each flag whose bit is zero. A flag whose condition still holds is set again on the next cycle.
- R10: `irq` is the OR of status bits [15:8] ANDed with enable bits [15:8]. Only the seven flag positions of the enable word are writable, so bit 10 and all others read 0.
- R11: Status bits [29:24] give the live receive byte count and bits [21:16] the live transmit byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when at 0x14) |
| reg_byte | input | 1 | 1 = 8-bit access on the receive pop |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| tx_valid | output | 1 | Transmit queue holds at least one byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Shift engine consumes `tx_byte` |
| rx_push | input | 1 | Shift engine delivers `rx_byte` |
| rx_byte | input | 8 | Received byte |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `xfer_done` is a single-cycle pulse.
- `reg_wr` and `reg_rd` are never raised together.
- The status clear write is the only way the done flag may fall.

The bench drives every strobe for exactly one clock, from the falling edge, and never overlaps a write with a read. Engine-side pushes and takes are issued only when no register access is in flight. This lets each expected count and flag be derived from a simple byte-queue model and the threshold arithmetic.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam logic [7:0] OFS_MODE = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_ENAB = 8'h08;
    localparam logic [7:0] OFS_TXQ  = 8'h10;
    localparam logic [7:0] OFS_RXQ  = 8'h14;

    // flag positions within status bits [15:8]
    localparam int F_TXE  = 7;
    localparam int F_DONE = 6;
    localparam int F_RXT  = 5;
    localparam int F_RXF  = 4;
    localparam int F_TXT  = 3;
    localparam int F_RNE  = 1;
    localparam int F_TNF  = 0;

    localparam logic [7:0] FLAG_KEEP = 8'hFB;
    localparam logic [5:0] TX_LVL_RST = 6'd4;
    localparam logic [5:0] RX_LVL_RST = 6'd3;

    typedef struct packed {
        logic done;
        logic rx_lvl;
        logic rx_full;
        logic tx_lvl;
    } sticky_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0]        push_n,
    input  logic [LANES*8-1:0]   din,
    input  logic [NW-1:0]        pop_n,
    output logic [LANES*8-1:0]   dout,
    output logic [CW-1:0]        count
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW:0]   free_w, push_w, pop_w, acc, take, cnt_nx;

    always_comb begin
        free_w = (CW+1)'(DEPTH) - {1'b0, count};
        push_w = (CW+1)'(push_n);
        pop_w  = (CW+1)'(pop_n);
        acc    = (push_w > free_w) ? free_w : push_w;
        take   = (pop_w > {1'b0, count}) ? {1'b0, count} : pop_w;
        cnt_nx = {1'b0, count} + acc - take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(acc);
            rd_ptr <= rd_ptr + PW'(take);
            count  <= cnt_nx[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if ((CW+1)'(i) < acc)
                mem[wr_ptr + PW'(i)] <= din[(LANES-1-i)*8 +: 8];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_peek
        assign dout[(LANES-1-g)*8 +: 8] =
            (CW'(g) < count) ? mem[rd_ptr + PW'(g)] : 8'h00;
    end
endmodule

// File: rtl/spi_evt_unit.sv
module spi_evt_unit
    import spi_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  tx_cnt,
    input  logic [5:0]  rx_cnt,
    input  logic        tx_full,
    input  logic        rx_full,
    input  logic [5:0]  tx_lvl,
    input  logic [5:0]  rx_lvl,
    input  logic        xfer_done,
    input  logic        clr_en,
    input  logic [7:0]  clr_bits,
    input  logic [7:0]  enab,
    output logic [31:0] evt_word,
    output logic        irq
);
    sticky_t    sq;
    logic [7:0] flags, clr;

    assign clr = clr_en ? clr_bits : 8'h00;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq <= '0;
        end else begin
            sq.done    <= (sq.done    & ~clr[F_DONE]) | xfer_done;
            sq.rx_lvl  <= (sq.rx_lvl  & ~clr[F_RXT])  | (rx_cnt > rx_lvl);
            sq.rx_full <= (sq.rx_full & ~clr[F_RXF])  | rx_full;
            sq.tx_lvl  <= (sq.tx_lvl  & ~clr[F_TXT])  | (tx_cnt <= tx_lvl);
        end
    end

    always_comb begin
        flags         = '0;
        flags[F_TXE]  = (tx_cnt == 6'd0);
        flags[F_DONE] = sq.done;
        flags[F_RXT]  = sq.rx_lvl;
        flags[F_RXF]  = sq.rx_full;
        flags[F_TXT]  = sq.tx_lvl;
        flags[F_RNE]  = (rx_cnt != 6'd0);
        flags[F_TNF]  = !tx_full;
        evt_word = {2'b00, rx_cnt, 2'b00, tx_cnt, flags, 8'h00};
        irq      = |(flags & enab);
    end
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_byte,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic        tx_take,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic        xfer_done,
    output logic        irq
);
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [31:0]   tx_peek, rx_peek, evt_word;
    logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [5:0]    tx_lvl_q, rx_lvl_q;
    logic [7:0]    mask_q;
    logic          unused_tx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_lvl_q <= TX_LVL_RST;
            rx_lvl_q <= RX_LVL_RST;
            mask_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_MODE) begin
                tx_lvl_q <= reg_wdata[13:8];
                rx_lvl_q <= reg_wdata[5:0];
            end
            if (reg_addr == OFS_ENAB)
                mask_q <= reg_wdata[15:8] & FLAG_KEEP;
        end
    end

    assign tx_push_n = (reg_wr && reg_addr == OFS_TXQ) ? 3'd4 : 3'd0;
    assign tx_pop_n  = (tx_take && tx_valid) ? 3'd1 : 3'd0;
    assign rx_push_n = rx_push ? 3'd1 : 3'd0;
    assign rx_pop_n  = (reg_rd && reg_addr == OFS_RXQ) ? (reg_byte ? 3'd1 : 3'd4) : 3'd0;

    byte_fifo #(.DEPTH(DEPTH), .LANES(4)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .din(reg_wdata),
        .pop_n(tx_pop_n), .dout(tx_peek), .count(tx_cnt)
    );

    byte_fifo #(.DEPTH(DEPTH), .LANES(4)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_push_n), .din({rx_byte, 24'h0}),
        .pop_n(rx_pop_n), .dout(rx_peek), .count(rx_cnt)
    );

    assign tx_valid  = (tx_cnt != '0);
    assign tx_byte   = tx_peek[31:24];
    assign unused_tx = ^tx_peek[23:0];

    spi_evt_unit u_evt (
        .clk(clk), .rst_n(rst_n),
        .tx_cnt(6'(tx_cnt)), .rx_cnt(6'(rx_cnt)),
        .tx_full(tx_cnt == CW'(DEPTH)), .rx_full(rx_cnt == CW'(DEPTH)),
        .tx_lvl(tx_lvl_q), .rx_lvl(rx_lvl_q),
        .xfer_done(xfer_done),
        .clr_en(reg_wr && reg_addr == OFS_STAT),
        .clr_bits(reg_wdata[15:8]),
        .enab(mask_q),
        .evt_word(evt_word), .irq(irq)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_MODE: reg_rdata = {18'h0, tx_lvl_q, 2'b00, rx_lvl_q};
            OFS_STAT: reg_rdata = evt_word;
            OFS_ENAB: reg_rdata = {16'h0, mask_q, 8'h00};
            OFS_RXQ:  reg_rdata = reg_byte ? {24'h0, rx_peek[31:24]} : rx_peek;
            default:  reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [7:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          rx_push,
    input logic          xfer_done,
    input logic          irq,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [7:0]    mask_q,
    input logic [31:0]   evt_word
);
    AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH)); // R2
    AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH)); // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0 && !rx_push) |=> rx_cnt == '0); // R4
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> evt_word[14]); // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_word[14] && !(reg_wr && reg_addr == 8'h04 && reg_wdata[14])) |=> evt_word[14]); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00) |-> !irq); // R10
endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_push(rx_push), .xfer_done(xfer_done),
    .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .mask_q(mask_q),
    .evt_word(evt_word)
);

// File: tb/tb_spi_fifo_irq.sv
module tb_spi_fifo_irq;
    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0, reg_byte = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_take = 0, rx_push = 0, xfer_done = 0, irq;
    logic [7:0]  tx_byte, rx_byte = 0;
    int          n_chk = 0, n_err = 0;
    logic [7:0]  txm[$];
    logic [7:0]  rxm[$];
    logic [31:0] v;

    always #5 clk = ~clk;

    spi_fifo_irq dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic b, output logic [31:0] d);
        reg_rd = 1; reg_addr = a; reg_byte = b;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0; reg_byte = 0;
        @(negedge clk);
    endtask

    task automatic push_tx(input logic [31:0] w);
        for (int i = 0; i < 4; i++)
            if (txm.size() < 32) txm.push_back(w[31-8*i -: 8]);
        wr(8'h10, w);
    endtask

    task automatic take_tx(input string tag);
        chk({tag, " tx_valid"}, {31'h0, tx_valid}, 1);
        chk({tag, " tx_byte"}, {24'h0, tx_byte}, {24'h0, txm.pop_front()});
        tx_take = 1; @(negedge clk); tx_take = 0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        if (rxm.size() < 32) rxm.push_back(b);
        rx_push = 1; rx_byte = b;
        @(negedge clk); rx_push = 0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w = 0;
        for (int i = 0; i < 4; i++)
            if (rxm.size() > 0) w[31-8*i -: 8] = rxm.pop_front();
        return w;
    endfunction

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(8'h00, 0, v); chk("R1 mode", v, 32'h0000_0403);
        rd(8'h08, 0, v); chk("R1 enable", v, 0);
        rd(8'h04, 0, v); chk("R1 status", v, 32'h0000_8900);
        chk("R1 irq", {31'h0, irq}, 0);

        // R2 / R11 transmit fill sweep with partial acceptance
        for (int k = 1; k <= 8; k++) begin
            push_tx({8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)});
            rd(8'h04, 0, v);
            chk("R11 tx count", {26'h0, v[21:16]}, 4*k);
            chk("R5 tx not full", {31'h0, v[8]}, (4*k < 32) ? 1 : 0);
        end
        take_tx("R2 a"); take_tx("R2 b");
        push_tx(32'hA0A1_A2A3);
        rd(8'h04, 0, v); chk("R2 partial push count", {26'h0, v[21:16]}, 32);
        push_tx(32'hB0B1_B2B3);
        rd(8'h04, 0, v); chk("R2 full push dropped", {26'h0, v[21:16]}, 32);
        while (txm.size() > 0) take_tx("R2 drain");
        chk("R2 tx_valid low", {31'h0, tx_valid}, 0);
        @(negedge clk);
        rd(8'h04, 0, v); chk("R5 tx empty", {16'h0, v[15:0]}, 32'h8900);

        // R5 / R9 clear-all leaves level flags, re-sets tx threshold flag
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 0, v); chk("R9 clear all", v, 32'h0000_8900);

        // R6 / R9 done flag
        xfer_done = 1; @(negedge clk); xfer_done = 0;
        repeat (5) @(negedge clk);
        rd(8'h04, 0, v); chk("R6 done sticky", {31'h0, v[14]}, 1);
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, 0, v); chk("R9 zero write keeps", {31'h0, v[14]}, 1);
        wr(8'h04, 32'h0000_4000);
        rd(8'h04, 0, v); chk("R9 done cleared", {31'h0, v[14]}, 0);

        // R3 R4 R7 R8 R11 receive fill sweep
        for (int n = 1; n <= 33; n++) begin
            push_rx(8'(n));
            rd(8'h04, 0, v);
            chk("R11 rx count", {26'h0, v[29:24]}, (n > 32) ? 32 : n);
            chk("R7 rx thr", {31'h0, v[13]}, (n > 3) ? 1 : 0);
            chk("R8 rx full", {31'h0, v[12]}, (n >= 32) ? 1 : 0);
            chk("R5 rx not empty", {31'h0, v[9]}, 1);
        end
        for (int i = 0; i < 7; i++) begin
            rd(8'h14, 0, v); chk("R3 word pop", v, model_word());
        end
        for (int i = 0; i < 4; i++) begin
            rd(8'h14, 1, v); chk("R4 byte pop", v, {24'h0, rxm.pop_front()});
        end
        rd(8'h14, 1, v); chk("R4 empty byte pop", v, 0);
        rd(8'h14, 0, v); chk("R4 empty word pop", v, 0);
        rd(8'h04, 0, v); chk("R4 count stays zero", {26'h0, v[29:24]}, 0);
        push_rx(8'hA1); push_rx(8'hA2);
        rd(8'h14, 0, v); chk("R3 partial word", v, 32'hA1A2_0000);
        void'(model_word());
        wr(8'h04, 32'h0000_3000);
        rd(8'h04, 0, v); chk("R9 rx flags cleared", {30'h0, v[13:12]}, 0);

        // R7 receive threshold sweep
        for (int t = 0; t <= 5; t += 5) begin
            wr(8'h00, {18'h0, 6'd4, 2'b00, 6'(t)});
            for (int k = 0; k <= 6; k++) begin
                wr(8'h04, 32'h0000_3000);
                for (int j = 0; j < k; j++) push_rx(8'(j));
                rd(8'h04, 0, v);
                chk("R7 rx thr sweep", {31'h0, v[13]}, (k > t) ? 1 : 0);
                while (rxm.size() > 0) begin
                    rd(8'h14, 0, v); chk("R3 sweep pop", v, model_word());
                end
            end
        end

        // R7 transmit threshold sweep
        wr(8'h00, 32'h0000_0803);
        rd(8'h00, 0, v); chk("R7 mode readback", v, 32'h0000_0803);
        for (int k = 0; k <= 3; k++) begin
            for (int j = 0; j < k; j++) push_tx({4{8'(16*k+j)}});
            wr(8'h04, 32'h0000_0800);
            rd(8'h04, 0, v);
            chk("R7 tx thr sweep", {31'h0, v[11]}, (4*k <= 8) ? 1 : 0);
            while (txm.size() > 0) take_tx("R2 sweep drain");
            @(negedge clk);
        end

        // R10 interrupt enable
        wr(8'h08, 32'h0000_FF00);
        rd(8'h08, 0, v); chk("R10 enable writable bits", v, 32'h0000_FB00);
        wr(8'h08, 32'h0000_0400);
        rd(8'h08, 0, v); chk("R10 bit10 not writable", v, 0);
        chk("R10 irq off", {31'h0, irq}, 0);
        wr(8'h08, 32'h0000_8000);
        chk("R10 irq tx empty", {31'h0, irq}, 1);
        wr(8'h08, 32'h0000_0200);
        chk("R10 irq rx empty masked", {31'h0, irq}, 0);
        push_rx(8'h55);
        chk("R10 irq rx not empty", {31'h0, irq}, 1);
        rd(8'h14, 1, v); chk("R4 single byte", v, 32'h55);
        void'(rxm.pop_front());
        chk("R10 irq drops", {31'h0, irq}, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule